// File: doc/BRIEF.md
# Vector element merge unit

This unit builds one 128-bit vector by interleaving elements taken from two 128-bit source vectors. The caller picks an element size (8, 16, 32 or 64 bits) and a half. In high mode the elements come from the left halves of both sources. In low mode they come from the right halves. Destination elements alternate between the first source and the second source, starting with the first.

A request strobe samples both sources, the size code and the half select at a single clock edge. The merged vector appears one cycle later together with a valid strobe. Results are computed from these sampled copies. A destination that names the same register as a source therefore needs no special ordering from the caller. A size code outside the supported set does not produce a result: the unit raises a specification-error flag for one cycle instead.

Top module: `vmrg_unit`

## Requirements
- R1: `size_i` selects the element width: code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. A vector holds 16 divided by the element byte count elements (16, 8, 4 or 2).
- R2: Element 0 is the leftmost element. Element e occupies bits [127-e*W : 128-(e+1)*W] for element width W.
- R3: Even-numbered destination elements are taken from `src_a_i`, and odd-numbered ones are taken from `src_b_i`.
- R4: In high mode (`low_i` = 0), destination element d takes source element d/2, using integer division.
- R5: In low mode (`low_i` = 1), destination element d takes source element (d+N)/2, where N is the element count.
- R6: A request with a size code of 4 or higher raises `spec_err_o` on the next cycle. In that cycle `valid_o` stays low and `res_o` keeps its previous value.
- R7: A legal request makes `valid_o` high and presents the result on `res_o` exactly one cycle later. The result depends only on the inputs sampled at the request edge, so input changes after that edge have no effect on it.
- R8: At 64-bit size, high mode yields {A[127:64], B[127:64]} and low mode yields {A[63:0], B[63:0]}.
- R9: In a cycle that follows no request, `valid_o` and `spec_err_o` are low and `res_o` holds its value.
- R10: Synchronous active-high reset clears `res_o`, `valid_o` and `spec_err_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe; samples all operands |
| size_i | input | 3 | Element size code (0..3 legal) |
| low_i | input | 1 | 0 = high halves, 1 = low halves |
| src_a_i | input | 128 | First source vector (even destination elements) |
| src_b_i | input | 128 | Second source vector (odd destination elements) |
| res_o | output | 128 | Merged vector, registered |
| valid_o | output | 1 | Result valid, one cycle after a legal request |
| spec_err_o | output | 1 | Illegal size code seen, one cycle after the request |

## Verification
Two events can share a cycle: a new request being sampled, and the result of the previous request being presented. A third case overlaps with these: an illegal request arriving while a legal result is on the output. The bench drives requests back to back with mixed sizes, halves and illegal codes. It also scrambles the sources right after each sampling edge. On every clock it compares the result, valid and error outputs against a behavioural model that keeps the last legal result. This shows whether the held value, the error flag and the new result each land in the right cycle.

// File: rtl/vmrg_pkg.sv
package vmrg_pkg;
  localparam int VEC_BITS  = 128;
  localparam int CODE_BITS = 3;
  localparam int SIZE_CNT  = 4;
  localparam int BASE_EW   = 8;
endpackage

// File: rtl/vmrg_size_dec.sv
module vmrg_size_dec #(
  parameter int CODE_W    = vmrg_pkg::CODE_BITS,
  parameter int NUM_SIZES = vmrg_pkg::SIZE_CNT
) (
  input  logic [CODE_W-1:0]    code_i,
  output logic [NUM_SIZES-1:0] sel_o,
  output logic                 legal_o
);
  always_comb begin
    sel_o = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (code_i == CODE_W'(k)) sel_o[k] = 1'b1;
    end
    legal_o = |sel_o;
  end
endmodule

// File: rtl/vmrg_interleave.sv
module vmrg_interleave #(
  parameter int VEC_W = vmrg_pkg::VEC_BITS,
  parameter int EW    = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] hi_o,
  output logic [VEC_W-1:0] lo_o
);
  localparam int N = VEC_W / EW;

  for (genvar d = 0; d < N; d++) begin : g_elem
    localparam int SRC_HI = d / 2;
    localparam int SRC_LO = (d + N) / 2;
    localparam int DTOP   = VEC_W - 1 - d * EW;
    localparam int HTOP   = VEC_W - 1 - SRC_HI * EW;
    localparam int LTOP   = VEC_W - 1 - SRC_LO * EW;
    if ((d % 2) == 0) begin : g_even
      assign hi_o[DTOP -: EW] = a_i[HTOP -: EW];
      assign lo_o[DTOP -: EW] = a_i[LTOP -: EW];
    end else begin : g_odd
      assign hi_o[DTOP -: EW] = b_i[HTOP -: EW];
      assign lo_o[DTOP -: EW] = b_i[LTOP -: EW];
    end
  end
endmodule

// File: rtl/vmrg_unit.sv
module vmrg_unit #(
  parameter int VEC_W     = vmrg_pkg::VEC_BITS,
  parameter int CODE_W    = vmrg_pkg::CODE_BITS,
  parameter int NUM_SIZES = vmrg_pkg::SIZE_CNT,
  parameter int MIN_EW    = vmrg_pkg::BASE_EW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CODE_W-1:0] size_i,
  input  logic              low_i,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  output logic [VEC_W-1:0]  res_o,
  output logic              valid_o,
  output logic              spec_err_o
);
  logic [NUM_SIZES-1:0] size_sel;
  logic                 size_ok;
  logic [VEC_W-1:0]     hi_v [NUM_SIZES];
  logic [VEC_W-1:0]     lo_v [NUM_SIZES];
  logic [VEC_W-1:0]     merged;

  vmrg_size_dec #(.CODE_W(CODE_W), .NUM_SIZES(NUM_SIZES)) u_dec (
    .code_i (size_i),
    .sel_o  (size_sel),
    .legal_o(size_ok)
  );

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int EW = MIN_EW << k;
    vmrg_interleave #(.VEC_W(VEC_W), .EW(EW)) u_ilv (
      .a_i (src_a_i),
      .b_i (src_b_i),
      .hi_o(hi_v[k]),
      .lo_o(lo_v[k])
    );
  end

  always_comb begin
    merged = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (size_sel[k]) merged = merged | (low_i ? lo_v[k] : hi_v[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      valid_o    <= 1'b0;
      spec_err_o <= 1'b0;
    end else begin
      valid_o    <= req_i & size_ok;
      spec_err_o <= req_i & ~size_ok;
      if (req_i && size_ok) res_o <= merged;
    end
  end
endmodule

// File: rtl/vmrg_unit_chk.sv
module vmrg_unit_chk #(
  parameter int VEC_W     = vmrg_pkg::VEC_BITS,
  parameter int CODE_W    = vmrg_pkg::CODE_BITS,
  parameter int NUM_SIZES = vmrg_pkg::SIZE_CNT
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic [CODE_W-1:0] size_i,
  input logic              low_i,
  input logic [VEC_W-1:0]  src_a_i,
  input logic [VEC_W-1:0]  src_b_i,
  input logic [VEC_W-1:0]  res_o,
  input logic              valid_o,
  input logic              spec_err_o
);
  localparam int H = VEC_W / 2;

  // R6
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && spec_err_o));

  // R7
  legal_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && size_i < CODE_W'(NUM_SIZES)) |=> (valid_o && !spec_err_o));

  // R6
  illegal_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && size_i >= CODE_W'(NUM_SIZES)) |=> (spec_err_o && !valid_o && $stable(res_o)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!valid_o && !spec_err_o && $stable(res_o)));

  // R8
  wide_high_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && size_i == CODE_W'(NUM_SIZES-1) && !low_i)
      |=> (res_o == {$past(src_a_i[VEC_W-1 -: H]), $past(src_b_i[VEC_W-1 -: H])}));

  // R8
  wide_low_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && size_i == CODE_W'(NUM_SIZES-1) && low_i)
      |=> (res_o == {$past(src_a_i[H-1:0]), $past(src_b_i[H-1:0])}));
endmodule

bind vmrg_unit vmrg_unit_chk #(
  .VEC_W(VEC_W), .CODE_W(CODE_W), .NUM_SIZES(NUM_SIZES)
) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .size_i(size_i), .low_i(low_i),
  .src_a_i(src_a_i), .src_b_i(src_b_i), .res_o(res_o),
  .valid_o(valid_o), .spec_err_o(spec_err_o)
);

// File: tb/vmrg_unit_tb_top.sv
module vmrg_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_i = 1'b0;
  logic [2:0]   size_i = '0;
  logic         low_i = 1'b0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic [127:0] res_o;
  logic         valid_o;
  logic         spec_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [127:0] exp_res = '0;
  logic         exp_valid = 1'b0;
  logic         exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmrg_unit dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .size_i(size_i), .low_i(low_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .res_o(res_o),
    .valid_o(valid_o), .spec_err_o(spec_err_o)
  );

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // behavioural reference: walk bit by bit over each destination element
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input int code, input bit lo);
    logic [127:0] r = '0;
    int bytes = 1 << code;
    int ew    = 8 * bytes;
    int n     = 16 / bytes;
    for (int d = 0; d < n; d++) begin
      int s = lo ? (d + n) / 2 : d / 2;
      for (int j = 0; j < ew; j++) begin
        r[127 - d*ew - j] = (d % 2 == 1) ? b[127 - s*ew - j] : a[127 - s*ew - j];
      end
    end
    return r;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (res_o !== exp_res || valid_o !== exp_valid || spec_err_o !== exp_err) begin
      n_bad++;
      $display("FAIL %s: actual res=%h v=%b e=%b expected res=%h v=%b e=%b",
               tag, res_o, valid_o, spec_err_o, exp_res, exp_valid, exp_err);
    end
  endtask

  task automatic step(input bit rq, input int code, input bit lo,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
    req_i   = rq;
    size_i  = 3'(code);
    low_i   = lo;
    src_a_i = a;
    src_b_i = b;
    exp_valid = rq && code < 4;
    exp_err   = rq && code >= 4;
    if (exp_valid) exp_res = model(a, b, code, lo);
    @(posedge clk);
    #1;
    src_a_i = rnd128();
    src_b_i = rnd128();
    size_i  = 3'($urandom_range(0, 7));
    low_i   = ~lo;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL R7: watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] ia, ib;
    for (int i = 0; i < 16; i++) begin
      ia[127 - 8*i -: 8] = 8'(i);
      ib[127 - 8*i -: 8] = 8'(8'h80 + i);
    end
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst = 1'b0;

    // R1 R2 R3 R4 R5: every legal size in both halves with indexed bytes
    for (int c = 0; c < 4; c++) begin
      step(1'b1, c, 1'b0, ia, ib, "R4 R3 R2 R1 high mode");
      step(1'b1, c, 1'b1, ia, ib, "R5 R3 R2 R1 low mode");
    end

    // R8: 64-bit with distinct halves
    step(1'b1, 3, 1'b0, {64'hA0A0_0000_0000_00A0, 64'hA1A1_1111_1111_11A1},
         {64'hB0B0_0000_0000_00B0, 64'hB1B1_1111_1111_11B1}, "R8 wide high");
    step(1'b1, 3, 1'b1, {64'hA0A0_0000_0000_00A0, 64'hA1A1_1111_1111_11A1},
         {64'hB0B0_0000_0000_00B0, 64'hB1B1_1111_1111_11B1}, "R8 wide low");

    // R6: illegal codes 4..7, result must hold
    for (int c = 4; c < 8; c++) step(1'b1, c, c[0], rnd128(), rnd128(), "R6 illegal size");

    // R9: idle cycles
    repeat (3) step(1'b0, 0, 1'b0, rnd128(), rnd128(), "R9 idle hold");

    // R7 R6: back-to-back mixed traffic with scrambled inputs after sampling
    for (int i = 0; i < 400; i++) begin
      int c = $urandom_range(0, 5);
      step(($urandom_range(0, 4) != 0), c, 1'($urandom), rnd128(), rnd128(),
           "R7 back-to-back");
    end

    // R10: reset in mid-traffic
    step(1'b1, 2, 1'b1, rnd128(), rnd128(), "R7 before reset");
    rst = 1'b1;
    exp_res = '0; exp_valid = 1'b0; exp_err = 1'b0;
    req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R10 reset after traffic");
    rst = 1'b0;
    req_i = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule